// File: doc/BRIEF.md
# Absolute Difference Accumulate Unit

This combinational unit forms the magnitude of the gap between two operands of parameterised width `XLEN`, reading them as two's-complement or as unsigned numbers under a mode select. The subtraction always takes the smaller operand from the larger. The unit adds the inverted smaller operand, the larger operand and one. An order test between the operands decides which operand is inverted.

When accumulation is enabled, the unit adds the difference to the current destination value and drops any carry beyond `XLEN` bits. It can also return a 4-bit condition field that classifies the final result. The field is present only when the record input is set. Its low bit carries the sticky overflow input unchanged. The unit has no clock and no state, and it does no saturation.

Top module: `absdiff_acc_unit`

## Requirements
- R1: When `src_a` orders below `src_b`, the difference is `~src_a + src_b + 1`, taken modulo 2^XLEN.
- R2: Otherwise the difference is `~src_b + src_a + 1`, taken modulo 2^XLEN. Equal operands give a difference of zero.
- R3: With `signed_mode`=1 the order test uses two's-complement ordering. With `signed_mode`=0 it uses unsigned ordering.
- R4: With `acc_en`=1, `result` is `dest_in` plus the difference, wrapping at XLEN bits. With `acc_en`=0, `result` is the difference alone and `dest_in` has no effect.
- R5: With `rec_en`=0, `cond_out` is 4'b0000.
- R6: With `rec_en`=1, `cond_out[3:1]` classifies `result` as a signed number: 3'b100 when negative (MSB set), 3'b010 when positive, 3'b001 when zero. `cond_out[0]` equals `sticky_ov`.
- R7: In signed mode, a difference beyond the signed range wraps without any indication. Its XLEN-bit unsigned value stays exact, so the most negative value against the most positive gives all ones.
- R8: `sticky_ov` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand |
| dest_in | input | XLEN | Current destination value, used as the accumulator |
| signed_mode | input | 1 | 1: two's-complement ordering, 0: unsigned ordering |
| acc_en | input | 1 | Add the difference to `dest_in` |
| rec_en | input | 1 | Produce the condition field |
| sticky_ov | input | 1 | Sticky overflow bit, copied into the condition field |
| result | output | XLEN | Difference, or the accumulated sum |
| cond_out | output | 4 | {negative, positive, zero, sticky overflow}, or zero |

## Verification
The bench builds the unit with `XLEN`=4. At that width it applies every pair of operands in both ordering modes. With accumulation on, it pairs each operand pair with all sixteen destination values. With accumulation off, it uses two unrelated destination values, which shows that `dest_in` is ignored. This small width makes the sign-boundary pairs easy to reach: the most negative against the most positive, values differing only in the MSB, and sums that carry out of the accumulator. Each of these is checked against arithmetic done in the bench.

// File: rtl/absdiff_pkg.sv
package absdiff_pkg;
  localparam int COND_W = 4;

  // Condition field layout, MSB first: negative, positive, zero, sticky.
  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
    logic so;
  } cond_t;
endpackage

// File: rtl/absdiff_cmp.sv
module absdiff_cmp #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            signed_mode,
  output logic            lt
);
  localparam int MSB = XLEN - 1;

  // Flipping the MSB maps two's-complement order onto unsigned order.
  function automatic logic [XLEN-1:0] bias(input logic [XLEN-1:0] v, input logic sgn);
    logic [XLEN-1:0] r;
    r = v;
    r[MSB] = v[MSB] ^ sgn;
    return r;
  endfunction

  logic [XLEN-1:0] a_key, b_key;

  always_comb begin
    a_key = bias(a, signed_mode);
    b_key = bias(b, signed_mode);
    lt    = (a_key < b_key);
  end
endmodule

// File: rtl/absdiff_sub.sv
module absdiff_sub #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            lt,
  output logic [XLEN-1:0] diff
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  // Inverted subtrahend plus minuend plus one.
  function automatic logic [XLEN-1:0] inv_add(input logic [XLEN-1:0] lo,
                                               input logic [XLEN-1:0] hi);
    return (~lo) + hi + ONE;
  endfunction

  logic [XLEN-1:0] small_op, large_op;

  always_comb begin
    small_op = lt ? a : b;
    large_op = lt ? b : a;
    diff     = inv_add(small_op, large_op);
  end
endmodule

// File: rtl/absdiff_accum.sv
module absdiff_accum
  import absdiff_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   diff,
  input  logic [XLEN-1:0]   dest_in,
  input  logic              acc_en,
  input  logic              rec_en,
  input  logic              sticky_ov,
  output logic [XLEN-1:0]   result,
  output logic [COND_W-1:0] cond
);
  localparam int MSB = XLEN - 1;

  function automatic cond_t classify(input logic [XLEN-1:0] v, input logic so);
    cond_t c;
    c.neg  = v[MSB];
    c.zero = (v == '0);
    c.pos  = !c.neg && !c.zero;
    c.so   = so;
    return c;
  endfunction

  cond_t cls;

  always_comb begin
    result = acc_en ? (dest_in + diff) : diff;
    cls    = classify(result, sticky_ov);
    cond   = rec_en ? cls : '0;
  end
endmodule

// File: rtl/absdiff_acc_unit.sv
module absdiff_acc_unit
  import absdiff_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [XLEN-1:0]   dest_in,
  input  logic              signed_mode,
  input  logic              acc_en,
  input  logic              rec_en,
  input  logic              sticky_ov,
  output logic [XLEN-1:0]   result,
  output logic [COND_W-1:0] cond_out
);
  // Named internal events, visible to the bound checker.
  logic            a_lt_b;
  logic [XLEN-1:0] diff;

  absdiff_cmp #(.XLEN(XLEN)) u_cmp (
    .a(src_a), .b(src_b), .signed_mode(signed_mode), .lt(a_lt_b)
  );

  absdiff_sub #(.XLEN(XLEN)) u_sub (
    .a(src_a), .b(src_b), .lt(a_lt_b), .diff(diff)
  );

  absdiff_accum #(.XLEN(XLEN)) u_acc (
    .diff(diff), .dest_in(dest_in), .acc_en(acc_en), .rec_en(rec_en),
    .sticky_ov(sticky_ov), .result(result), .cond(cond_out)
  );
endmodule

// File: rtl/absdiff_acc_chk.sv
module absdiff_acc_chk #(
  parameter int XLEN = 64
) (
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] dest_in,
  input logic            signed_mode,
  input logic            acc_en,
  input logic            rec_en,
  input logic            sticky_ov,
  input logic [XLEN-1:0] result,
  input logic [3:0]      cond_out,
  input logic            a_lt_b,
  input logic [XLEN-1:0] diff
);
  always_comb begin
    if (a_lt_b)
      p_lt_order_r1: assert (diff == src_b - src_a);
    if (!a_lt_b)
      p_ge_order_r2: assert (diff == src_a - src_b);
    if (signed_mode)
      p_signed_cmp_r3: assert (a_lt_b == ($signed(src_a) < $signed(src_b)));
    else
      p_unsigned_cmp_r3: assert (a_lt_b == (src_a < src_b));
    if (acc_en)
      p_accum_r4: assert (result == dest_in + diff);
    else
      p_pass_r4: assert (result == diff);
    if (!rec_en)
      p_cond_off_r5: assert (cond_out == 4'b0000);
    if (rec_en)
      p_cond_class_r6: assert ($onehot(cond_out[3:1]) && cond_out[0] == sticky_ov);
  end
endmodule

bind absdiff_acc_unit absdiff_acc_chk #(.XLEN(XLEN)) i_chk (
  .src_a(src_a), .src_b(src_b), .dest_in(dest_in), .signed_mode(signed_mode),
  .acc_en(acc_en), .rec_en(rec_en), .sticky_ov(sticky_ov), .result(result),
  .cond_out(cond_out), .a_lt_b(a_lt_b), .diff(diff)
);

// File: tb/test_absdiff_acc_unit.sv
module test_absdiff_acc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int SPAN = 1 << W;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] src_a, src_b, dest_in, result;
  logic signed_mode, acc_en, rec_en, sticky_ov;
  logic [3:0] cond_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  absdiff_acc_unit #(.XLEN(W)) i_absdiff_acc_unit (
    .src_a(src_a), .src_b(src_b), .dest_in(dest_in), .signed_mode(signed_mode),
    .acc_en(acc_en), .rec_en(rec_en), .sticky_ov(sticky_ov),
    .result(result), .cond_out(cond_out)
  );

  function automatic int sval(input int v, input bit sgn);
    return (sgn && v >= SPAN/2) ? v - SPAN : v;
  endfunction

  task automatic drive(input int a, input int b, input int d, input bit sm,
                       input bit ac, input bit rc, input bit so);
    @(posedge clk);
    src_a = W'(a); src_b = W'(b); dest_in = W'(d);
    signed_mode = sm; acc_en = ac; rec_en = rc; sticky_ov = so;
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected values from plain integer arithmetic.
  task automatic check_vec(input int a, input int b, input int d, input bit sm,
                           input bit ac, input bit rc, input bit so);
    int sa, sb, mag, res, c3;
    sa  = sval(a, sm);
    sb  = sval(b, sm);
    mag = (sa < sb) ? (sb - sa) : (sa - sb);
    res = ((ac ? d : 0) + mag) % SPAN;
    if (res >= SPAN/2) c3 = 4;
    else if (res == 0) c3 = 1;
    else c3 = 2;
    drive(a, b, d, sm, ac, rc, so);
    if (sa < sb) check(ac ? "R1/R4" : "R1", int'(result), res);
    else         check(ac ? "R2/R4" : "R2", int'(result), res);
    if (rc) check("R6", int'(cond_out), c3 * 2 + int'(so));
    else    check("R5", int'(cond_out), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Idle state: all inputs zero gives zero result and no condition.
    drive(0, 0, 0, 0, 0, 0, 0);
    check("R5 idle result", int'(result), 0);
    check("R5 idle cond", int'(cond_out), 0);

    // R7: most negative against most positive, signed: all ones.
    drive(8, 7, 0, 1, 0, 1, 0);
    check("R7 min vs max", int'(result), 15);
    check("R7 cond neg", int'(cond_out), 8);
    // R3: same bits read unsigned give one.
    drive(8, 7, 0, 0, 0, 0, 0);
    check("R3 unsigned order", int'(result), 1);
    // R2: equal operands give zero, cond zero class.
    drive(5, 5, 0, 1, 0, 1, 1);
    check("R2 equal", int'(result), 0);
    check("R6 zero class", int'(cond_out), 3);
    // R4: accumulator wrap 14 + 3 -> 1.
    drive(2, 5, 14, 0, 1, 1, 0);
    check("R4 wrap", int'(result), 1);
    // R8: sticky bit leaves result untouched.
    drive(2, 5, 14, 0, 1, 1, 1);
    check("R8 sticky no effect", int'(result), 1);
    // R4: dest_in ignored when not accumulating.
    drive(3, 9, 11, 0, 0, 0, 0);
    check("R4 dest ignored", int'(result), 6);

    for (int sm = 0; sm < 2; sm++)
      for (int ac = 0; ac < 2; ac++)
        for (int a = 0; a < SPAN; a++)
          for (int b = 0; b < SPAN; b++) begin
            if (ac == 1) begin
              for (int d = 0; d < SPAN; d++)
                check_vec(a, b, d, sm[0], 1'b1, d[0] ^ a[0], b[0]);
            end else begin
              check_vec(a, b, 0, sm[0], 1'b0, a[0], b[1]);
              check_vec(a, b, 9, sm[0], 1'b0, ~a[0], b[1]);
            end
          end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule